// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer of a windowed integer register file whose number of windows is a parameter, not required to be a power of two. Each cycle it may accept one request: move down a window (save), move up a window (restore), return from a trap, or write the processor status word. A move goes to the neighbouring window with wrap-around modulo the window count. It is refused when the target window is flagged in a per-window invalid mask that the surrounding core supplies.

When a request is refused, the block raises a one-cycle trap strobe with a code for window overflow, window underflow or illegal instruction. The pointer and the status fields keep their values. The block also presents the packed status word for reads, and the physical base row of the active window for the register file address path.

Top module: `winptr_ctrl`

## Requirements
- R1: A save request (op_code 1) sets the pointer to the current value minus one. From window 0 it goes to window NWIN-1.
- R2: A restore request (op_code 2) sets the pointer to the current value plus one. From window NWIN-1 it goes to window 0.
- R3: If the invalid mask bit indexed by the save target is set, the save raises trap code 1 (overflow), and the pointer and status word keep their values.
- R4: If the invalid mask bit indexed by the upward target of a restore, or of a trap return, is set, the request raises trap code 2 (underflow), and the pointer and status word keep their values.
- R5: A trap return (op_code 3) while the enable-traps bit is 1 raises trap code 3 (illegal) and changes nothing.
- R6: A permitted trap return does three things: it sets enable-traps to 1, moves the pointer up with the R2 wrap, and copies previous-supervisor into supervisor.
- R7: A status write (op_code 4) whose pointer field wr_data[4:0] is greater than or equal to NWIN raises trap code 3 and changes nothing.
- R8: A permitted status write loads every field from wr_data. The status word layout is: pointer in [4:0], enable-traps [5], previous-supervisor [6], supervisor [7], interrupt level [11:8], FP enable [12], condition codes [23:20]. All other bits read 0.
- R9: base_row always equals the pointer times 16.
- R10: After reset the pointer is 0, supervisor is 1, all other status fields are 0 (status word 0x80), and trap_valid is 0.
- R11: Pointer, status word, base row and the trap strobe all reflect a request one clock after it is presented. trap_valid is high for exactly the cycles that follow refused requests. trap_code is 0 when no trap is flagged.
- R12: With op_valid low, nothing changes and no trap is raised, whatever op_code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | 1 save, 2 restore, 3 trap return, 4 status write |
| wr_data | input | 32 | Status word value for a status write |
| wim | input | NWIN | Invalid window mask, bit i flags window i |
| cwp | output | PW | Current window pointer |
| status_word | output | 32 | Packed status word |
| base_row | output | PW+4 | Physical base row of active window |
| trap_valid | output | 1 | One-cycle trap strobe |
| trap_code | output | 2 | 1 overflow, 2 underflow, 3 illegal |

## Verification
Every result of this block is due exactly one clock after its request: the pointer, the status word, the base row and the trap strobe are all updated at the edge that consumes the request. The driver tags each expected result with the cycle number in which it presented the request. The monitor compares a result only on the falling edge after the next rising edge, so none is sampled early or late. Back-to-back refused requests and idle cycles with a stale op_code confirm that the strobe lasts one cycle per refusal.

// File: rtl/winptr_pkg.sv
package winptr_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SAVE    = 3'd1,
    OP_RESTORE = 3'd2,
    OP_RETT    = 3'd3,
    OP_WRSTAT  = 3'd4
  } winop_e;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_WOVF = 2'd1,
    TRAP_WUNF = 2'd2,
    TRAP_ILL  = 2'd3
  } trap_e;

  localparam int SW_PTR_W  = 5;
  localparam int SW_ET_BIT = 5;
  localparam int SW_PS_BIT = 6;
  localparam int SW_S_BIT  = 7;
  localparam int SW_PIL_LO = 8;
  localparam int SW_EF_BIT = 12;
  localparam int SW_CC_LO  = 20;

  typedef struct packed {
    logic [3:0] cc;
    logic       ef;
    logic [3:0] pil;
    logic       sup;
    logic       psup;
    logic       et;
  } stat_t;

endpackage

// File: rtl/winptr_step.sv
module winptr_step #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic [PW-1:0] cur,
  output logic [PW-1:0] dn,
  output logic [PW-1:0] up
);
  localparam logic [PW-1:0] LAST = PW'(NWIN - 1);

  always_comb begin
    if (cur == '0) dn = LAST;
    else           dn = cur - PW'(1);
    if (cur == LAST) up = '0;
    else             up = cur + PW'(1);
  end
endmodule

// File: rtl/winptr_mask_chk.sv
module winptr_mask_chk #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic [NWIN-1:0] wim,
  input  logic [PW-1:0]   dn,
  input  logic [PW-1:0]   up,
  output logic            dn_blocked,
  output logic            up_blocked
);
  logic [NWIN-1:0] dn_hot;
  logic [NWIN-1:0] up_hot;

  for (genvar i = 0; i < NWIN; i++) begin : g_dec
    assign dn_hot[i] = (dn == PW'(i)) && wim[i];
    assign up_hot[i] = (up == PW'(i)) && wim[i];
  end

  assign dn_blocked = |dn_hot;
  assign up_blocked = |up_hot;
endmodule

// File: rtl/winptr_stat_pack.sv
module winptr_stat_pack #(
  parameter int PW = 3
) (
  input  winptr_pkg::stat_t st,
  input  logic [PW-1:0]     ptr,
  output logic [31:0]       word
);
  import winptr_pkg::*;

  always_comb begin
    word = '0;
    word[PW-1:0]             = ptr;
    word[SW_ET_BIT]          = st.et;
    word[SW_PS_BIT]          = st.psup;
    word[SW_S_BIT]           = st.sup;
    word[SW_PIL_LO +: 4]     = st.pil;
    word[SW_EF_BIT]          = st.ef;
    word[SW_CC_LO +: 4]      = st.cc;
  end
endmodule

// File: rtl/winptr_ctrl.sv
module winptr_ctrl #(
  parameter int NWIN = 8,
  parameter int PW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [31:0]     wr_data,
  input  logic [NWIN-1:0] wim,
  output logic [PW-1:0]   cwp,
  output logic [31:0]     status_word,
  output logic [PW+3:0]   base_row,
  output logic            trap_valid,
  output logic [1:0]      trap_code
);
  import winptr_pkg::*;

  localparam int RW = PW + 4;

  logic [PW-1:0] cwp_q, cwp_d;
  logic [PW-1:0] ptr_dn, ptr_up;
  logic          dn_blk, up_blk;
  stat_t         st_q, st_d;
  trap_e         trap_d;
  logic [RW-1:0] base_q;
  logic          wr_ptr_bad;
  winop_e        op;

  assign op         = winop_e'(op_code);
  assign wr_ptr_bad = int'(wr_data[SW_PTR_W-1:0]) >= NWIN;

  winptr_step #(.NWIN(NWIN), .PW(PW)) u_step (
    .cur (cwp_q),
    .dn  (ptr_dn),
    .up  (ptr_up)
  );

  winptr_mask_chk #(.NWIN(NWIN), .PW(PW)) u_mask (
    .wim        (wim),
    .dn         (ptr_dn),
    .up         (ptr_up),
    .dn_blocked (dn_blk),
    .up_blocked (up_blk)
  );

  always_comb begin
    cwp_d  = cwp_q;
    st_d   = st_q;
    trap_d = TRAP_NONE;
    if (op_valid) begin
      case (op)
        OP_SAVE: begin
          if (dn_blk) trap_d = TRAP_WOVF;
          else        cwp_d  = ptr_dn;
        end
        OP_RESTORE: begin
          if (up_blk) trap_d = TRAP_WUNF;
          else        cwp_d  = ptr_up;
        end
        OP_RETT: begin
          if (st_q.et) begin
            trap_d = TRAP_ILL;
          end else if (up_blk) begin
            trap_d = TRAP_WUNF;
          end else begin
            cwp_d      = ptr_up;
            st_d.et    = 1'b1;
            st_d.sup   = st_q.psup;
          end
        end
        OP_WRSTAT: begin
          if (wr_ptr_bad) begin
            trap_d = TRAP_ILL;
          end else begin
            cwp_d     = wr_data[PW-1:0];
            st_d.et   = wr_data[SW_ET_BIT];
            st_d.psup = wr_data[SW_PS_BIT];
            st_d.sup  = wr_data[SW_S_BIT];
            st_d.pil  = wr_data[SW_PIL_LO +: 4];
            st_d.ef   = wr_data[SW_EF_BIT];
            st_d.cc   = wr_data[SW_CC_LO +: 4];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q      <= '0;
      st_q       <= '0;
      st_q.sup   <= 1'b1;
      base_q     <= '0;
      trap_valid <= 1'b0;
      trap_code  <= 2'd0;
    end else begin
      cwp_q      <= cwp_d;
      st_q       <= st_d;
      base_q     <= {cwp_d, 4'b0000};
      trap_valid <= (trap_d != TRAP_NONE);
      trap_code  <= trap_d;
    end
  end

  winptr_stat_pack #(.PW(PW)) u_pack (
    .st   (st_q),
    .ptr  (cwp_q),
    .word (status_word)
  );

  assign cwp      = cwp_q;
  assign base_row = base_q;
endmodule

// File: rtl/winptr_ctrl_chk.sv
module winptr_ctrl_chk #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic [31:0]     wr_data,
  input logic [NWIN-1:0] wim,
  input logic [PW-1:0]   cwp,
  input logic [31:0]     status_word,
  input logic [PW+3:0]   base_row,
  input logic            trap_valid,
  input logic [1:0]      trap_code
);
  localparam logic [PW-1:0] LAST = PW'(NWIN - 1);

  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(cwp) < NWIN); // R1

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd1) |=>
      (trap_valid || cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - PW'(1)))); // R1

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd2) |=>
      (trap_valid || cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + PW'(1)))); // R2

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> ($stable(cwp) && $stable(status_word))); // R3

  AST_RETT_ILL: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd3 && status_word[5]) |=>
      (trap_valid && trap_code == 2'd3)); // R5

  AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd4 && int'(wr_data[4:0]) >= NWIN) |=>
      (trap_valid && trap_code == 2'd3)); // R7

  AST_BASE_ROW: assert property (@(posedge clk) disable iff (rst)
    base_row == {cwp, 4'b0000}); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!trap_valid && $stable(cwp) && $stable(status_word))); // R12

  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> trap_code == 2'd0); // R11
endmodule

bind winptr_ctrl winptr_ctrl_chk #(.NWIN(NWIN), .PW(PW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .wr_data     (wr_data),
  .wim         (wim),
  .cwp         (cwp),
  .status_word (status_word),
  .base_row    (base_row),
  .trap_valid  (trap_valid),
  .trap_code   (trap_code)
);

// File: tb/winptr_ctrl_tb.sv
module winptr_ctrl_tb;
  localparam int N  = 6;
  localparam int PW = 3;

  logic          clk = 0;
  logic          rst;
  logic          op_valid;
  logic [2:0]    op_code;
  logic [31:0]   wr_data;
  logic [N-1:0]  wim;
  logic [PW-1:0] cwp;
  logic [31:0]   status_word;
  logic [PW+3:0] base_row;
  logic          trap_valid;
  logic [1:0]    trap_code;

  always #2.5 clk = ~clk;

  winptr_ctrl #(.NWIN(N)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .wr_data(wr_data), .wim(wim), .cwp(cwp), .status_word(status_word),
    .base_row(base_row), .trap_valid(trap_valid), .trap_code(trap_code)
  );

  typedef struct {
    int          cyc;
    int          ecwp;
    logic [31:0] eword;
    logic        etv;
    logic [1:0]  etc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc_cnt = 0;
  int checks  = 0;
  int errors  = 0;

  int m_cwp, m_pil, m_cc;
  logic m_et, m_ps, m_s, m_ef;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [31:0] pack_word();
    return 32'(m_cwp) | (32'(m_et) << 5) | (32'(m_ps) << 6) | (32'(m_s) << 7) |
           (32'(m_pil) << 8) | (32'(m_ef) << 12) | (32'(m_cc) << 20);
  endfunction

  task automatic compare(input string tag, input int ecwp, input logic [31:0] ew,
                         input logic etv, input logic [1:0] etc);
    checks++;
    if (int'(cwp) != ecwp || status_word != ew || int'(base_row) != ecwp * 16 ||
        trap_valid != etv || trap_code != etc) begin
      errors++;
      $display("FAIL %s: got cwp=%0d word=%h base=%0d tv=%0d tc=%0d, expected cwp=%0d word=%h base=%0d tv=%0d tc=%0d",
               tag, cwp, status_word, base_row, trap_valid, trap_code,
               ecwp, ew, ecwp * 16, etv, etc);
    end
  endtask

  // monitor: pops results whose request edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc < cyc_cnt) begin
      exp_t it;
      it = q.pop_front();
      compare(it.tag, it.ecwp, it.eword, it.etv, it.etc);
    end
  end

  // driver: presents a request and pushes the expected result
  task automatic drive(input logic v, input logic [2:0] op, input logic [31:0] d,
                       input logic [N-1:0] m, input string tag);
    int dn, up;
    exp_t it;
    @(negedge clk);
    op_valid = v; op_code = op; wr_data = d; wim = m;
    dn = (m_cwp == 0) ? N - 1 : m_cwp - 1;
    up = (m_cwp == N - 1) ? 0 : m_cwp + 1;
    it.etv = 0; it.etc = 0;
    if (v) begin
      case (op)
        3'd1: if (m[dn]) begin it.etv = 1; it.etc = 1; end else m_cwp = dn;
        3'd2: if (m[up]) begin it.etv = 1; it.etc = 2; end else m_cwp = up;
        3'd3: begin
          if (m_et) begin it.etv = 1; it.etc = 3; end
          else if (m[up]) begin it.etv = 1; it.etc = 2; end
          else begin m_cwp = up; m_et = 1; m_s = m_ps; end
        end
        3'd4: begin
          if (int'(d[4:0]) >= N) begin it.etv = 1; it.etc = 3; end
          else begin
            m_cwp = int'(d[4:0]); m_et = d[5]; m_ps = d[6]; m_s = d[7];
            m_pil = int'(d[11:8]); m_ef = d[12]; m_cc = int'(d[23:20]);
          end
        end
        default: ;
      endcase
    end
    it.cyc = cyc_cnt; it.ecwp = m_cwp; it.eword = pack_word(); it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; op_valid = 0; op_code = 0; wr_data = 0; wim = 0;
    m_cwp = 0; m_pil = 0; m_cc = 0; m_et = 0; m_ps = 0; m_s = 1; m_ef = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R10 reset", 0, 32'h80, 1'b0, 2'd0);

    drive(0, 3'd1, 0, '1, "R12 idle with save code");
    drive(1, 3'd1, 0, '0, "R1 save wrap 0->5");
    drive(1, 3'd1, 0, '0, "R1 R9 save 5->4");
    drive(1, 3'd2, 0, '0, "R2 restore 4->5");
    drive(1, 3'd2, 0, '0, "R2 restore wrap 5->0");
    drive(1, 3'd1, 0, 6'b100000, "R3 save overflow");
    drive(1, 3'd2, 0, 6'b000010, "R4 restore underflow");
    drive(1, 3'd4, 32'h0000_00E6, '0, "R7 write ptr 6");
    drive(1, 3'd4, 32'h0000_0007, '0, "R7 write ptr 7");
    drive(1, 3'd4, 32'h0000_001F, '0, "R7 write ptr 31");
    drive(1, 3'd4, 32'h0050_1A43, '0, "R8 write fields");
    drive(1, 3'd3, 0, '0, "R6 trap return");
    drive(1, 3'd3, 0, '0, "R5 trap return with ET set");
    drive(1, 3'd4, 32'h00F0_0085, '0, "R8 write ptr 5");
    drive(1, 3'd3, 0, 6'b000001, "R4 trap return underflow");
    drive(1, 3'd3, 0, '0, "R6 trap return wrap");
    drive(1, 3'd1, 0, '1, "R11 trap back to back 1");
    drive(1, 3'd2, 0, '1, "R11 trap back to back 2");
    drive(0, 3'd4, 32'h0000_0003, '0, "R12 idle stale write");
    for (int i = 0; i < 8; i++) drive(1, 3'd1, 0, '0, "R1 save loop");
    for (int i = 0; i < 3; i++) drive(1, 3'd2, 0, '0, "R2 restore loop");
    drive(0, 3'd0, 0, '0, "R11 strobe idle");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule